// File: doc/BRIEF.md
# Continuous ADC Conversion Sequencer

This block is the control side of a converter that runs conversion after conversion without software help. A single 32-bit configuration word, written over a plain write strobe and data bus, sets the conversion length code, the positive and negative input selects, the conversion clock rate and the run enable. The block derives two conversion-clock enables from its 12 MHz system clock, one at 6 MHz and one at 1 MHz. It counts conversion clocks for each conversion, drives the input select codes to the external multiplexer, and raises a one-cycle done strobe at the end of every conversion. In that same cycle it captures a 16-bit sample word and masks it to the resolution the length code provides.

Two events lengthen a conversion. When the enable goes from 0 to 1, the block first waits 21 ticks of the 1 MHz enable so that the analog side can settle. The first conversion then runs for twice its normal length. If a write changes the word while a conversion is in flight, that conversion starts again at double length. The configuration word reads back with a sticky flag in bit 31. The flag reports that the last write put a reserved code in one of the input selects.

Top module: `adc_seq`

## Requirements
- R1: After reset, the readback is 0x00001800 with bit 31 (error flag) clear, the done strobe is low and both select outputs are 0.
- R2: Bits [15:13] of the word hold a length code N, and a normal conversion lasts 32<<N conversion clocks. Bit [2] selects the conversion clock: 0 selects an enable every 2 system cycles (6 MHz) and 1 selects an enable every 12 system cycles (1 MHz).
- R3: A write that sets bit [0] (enable) while it was clear starts a settle wait of 21 ticks at 12 system cycles each. The first conversion follows and lasts 2*(32<<N) conversion clocks. With N=0 on the 6 MHz clock, done rises 380 cycles after the cycle that accepts the write.
- R4: While bit [0] stays set, conversions run back to back. The done strobe is high for exactly one cycle at the end of each conversion.
- R5: In the done cycle, the result takes the sample input with all but its top 7+N bits cleared. The result holds its value between done strobes.
- R6: A write that clears bit [0] stops the sequence at once. No done strobe follows and the result keeps its value.
- R7: A write that changes any bit of the word while a conversion runs and leaves bit [0] set restarts that conversion from zero at twice its normal length, with no done strobe for the interrupted one.
- R8: A write of the value already held changes nothing, and the next done strobe comes at its normal time.
- R9: A write with a reserved code (0x6, 0x7 or 0xC to 0xF) in bits [10:7] or bits [6:3] sets readback bit 31. A later write with valid codes in both fields clears it.
- R10: The positive select output follows bits [10:7] of the word and the negative select output follows bits [6:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration readback, error flag in bit 31 |
| sample_in | input | 16 | Left-justified raw sample from the converter |
| sel_pos | output | 4 | Positive input select code |
| sel_neg | output | 4 | Negative input select code |
| conv_done | output | 1 | One-cycle end-of-conversion strobe |
| result | output | 16 | Masked sample captured at the end of conversion |

## Verification
A wrong phase or count state shows at the ports as a done strobe that arrives early, late or not at all. The bench therefore measures the distance in cycles between done strobes, and between each write and the following done strobe, against figures worked out from the length code, the clock select and the settle wait. A wrong doubling flag shows up within one conversion as a gap of twice or half the expected length. A divider that drifts is caught on the 1 MHz runs, where each slip of one cycle adds to the measured gap. A stale configuration or a wrong mask shows in the captured result word and on the select pins during the same run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CFG_W     = 32;
  localparam int MUX_W     = 4;
  localparam int CODE_W    = 3;
  localparam int RES_W     = 16;
  localparam int BASE_BITS = 7;
  localparam int CNT_W     = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} seq_state_e;

  // Conversion clocks for a length code, optionally doubled.
  function automatic logic [CNT_W-1:0] conv_ticks(input logic [CODE_W-1:0] code,
                                                  input logic dbl);
    logic [CNT_W-1:0] t;
    t = CNT_W'(32) << code;
    if (dbl) t = t << 1;
    return t;
  endfunction

  // Keep the top 7+code bits of a left-justified sample.
  function automatic logic [RES_W-1:0] res_mask(input logic [CODE_W-1:0] code);
    int sh;
    sh = RES_W - BASE_BITS - int'(code);
    return {RES_W{1'b1}} << sh;
  endfunction

  function automatic logic mux_code_ok(input logic [MUX_W-1:0] c);
    return !((c == 4'h6) || (c == 4'h7) || (c >= 4'hC));
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 32'h0000_1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             err,
  output logic             start,
  output logic             stop,
  output logic             change
);

  logic codes_ok;

  assign codes_ok = mux_code_ok(wdata[10:7]) && mux_code_ok(wdata[6:3]);
  assign start    = we && !cfg[0] && wdata[0];
  assign stop     = we && cfg[0] && !wdata[0];
  assign change   = we && cfg[0] && wdata[0] && (wdata != cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= RESET_VAL;
      err <= 1'b0;
    end else if (we) begin
      cfg <= wdata;
      err <= !codes_ok;
    end
  end

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !codes_ok) |=> err); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && codes_ok) |=> !err); // R9
  AST_SAME_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wdata == cfg)) |-> !(change || start || stop)); // R8

endmodule

// File: rtl/adc_seq_tickgen.sv
module adc_seq_tickgen #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic slow,
  output logic tick
);

  localparam int DIV_W = $clog2(SLOW_DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;

  assign div_last = slow ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
  assign tick     = run && (div_cnt == div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (restart || !run)   div_cnt <= '0;
    else if (div_cnt >= div_last) div_cnt <= '0;
    else                        div_cnt <= div_cnt + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < DIV_W'(SLOW_DIV)); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !slow && !restart) |=> !tick); // R2

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_TICKS = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              change,
  input  logic [CODE_W-1:0] code,
  input  logic              tick,
  input  logic [RES_W-1:0]  sample,
  output seq_state_e        state,
  output logic              restart,
  output logic              done,
  output logic [RES_W-1:0]  result
);

  logic [CNT_W-1:0] cnt;
  logic             dbl;
  logic [CNT_W-1:0] target;
  logic             settle_end;
  logic             conv_end;
  logic             conv_change;

  assign target      = conv_ticks(code, dbl);
  assign conv_change = change && (state == ST_CONV);
  assign restart     = start || conv_change;
  assign settle_end  = (state == ST_SETTLE) && tick && (cnt == CNT_W'(SETTLE_TICKS - 1));
  assign conv_end    = (state == ST_CONV) && tick && !conv_change && (cnt == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      dbl    <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (stop) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            state <= ST_SETTLE;
            cnt   <= '0;
            dbl   <= 1'b1;
          end
          ST_SETTLE: if (settle_end) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
          ST_CONV: if (conv_change) begin
            cnt <= '0;
            dbl <= 1'b1;
          end else if (conv_end) begin
            cnt    <= '0;
            dbl    <= 1'b0;
            done   <= 1'b1;
            result <= sample & res_mask(code);
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_SETTLE) && (cnt == '0) && dbl); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_CONV)); // R4
  AST_RESULT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result & ~res_mask(code)) == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R5
  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == ST_IDLE) && !done); // R6
  AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    conv_change |=> dbl && (cnt == '0) && !done); // R7

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int FAST_DIV     = 2,
  parameter int SLOW_DIV     = 12,
  parameter int SETTLE_TICKS = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [15:0] sample_in,
  output logic [3:0]  sel_pos,
  output logic [3:0]  sel_neg,
  output logic        conv_done,
  output logic [15:0] result
);

  logic [CFG_W-1:0] cfg;
  logic             err;
  logic             start;
  logic             stop;
  logic             change;
  logic             tick;
  logic             restart;
  logic             run;
  logic             slow;
  seq_state_e       state;

  adc_seq_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .cfg    (cfg),
    .err    (err),
    .start  (start),
    .stop   (stop),
    .change (change)
  );

  assign run  = (state != ST_IDLE);
  assign slow = (state == ST_SETTLE) || cfg[2];

  adc_seq_tickgen #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .slow    (slow),
    .tick    (tick)
  );

  adc_seq_ctrl #(
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .stop    (stop),
    .change  (change),
    .code    (cfg[15:13]),
    .tick    (tick),
    .sample  (sample_in),
    .state   (state),
    .restart (restart),
    .done    (conv_done),
    .result  (result)
  );

  assign reg_rdata = {err, cfg[30:0]};
  assign sel_pos   = cfg[10:7];
  assign sel_neg   = cfg[6:3];

  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (sel_pos == $past(reg_wdata[10:7])) && (sel_neg == $past(reg_wdata[6:3]))); // R10
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] |-> !conv_done); // R6

endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] sample_in = 16'hFFFF;
  logic [3:0]  sel_pos;
  logic [3:0]  sel_neg;
  logic        conv_done;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  adc_seq u_adc_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sample_in (sample_in),
    .sel_pos   (sel_pos),
    .sel_neg   (sel_neg),
    .conv_done (conv_done),
    .result    (result)
  );

  // Vector table: word, write-to-done cycles, done-to-done cycles, result for sample 0xFFFF
  localparam int NVEC = 4;
  localparam logic [31:0] VEC_CFG    [NVEC] = '{32'h0000_00C1, 32'h0000_2149, 32'h0000_01D5, 32'h0000_4259};
  localparam int          VEC_FIRST  [NVEC] = '{380, 508, 1020, 764};
  localparam int          VEC_STEADY [NVEC] = '{64, 128, 384, 256};
  localparam logic [15:0] VEC_RES    [NVEC] = '{16'hFE00, 16'hFF00, 16'hFE00, 16'hFF80};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (conv_done) break;
      if (n > 20000) begin
        n = -1;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd200000, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    int dones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 32'h0000_1800, "R1 readback", reg_rdata, 32'h0000_1800);
    chk(!conv_done && sel_pos == 4'h0 && sel_neg == 4'h0, "R1 outputs",
        {conv_done, sel_pos, sel_neg}, 32'h0);

    // Table walk: R2 R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      sample_in = 16'hFFFF;
      wr(VEC_CFG[i]);
      chk(sel_pos == VEC_CFG[i][10:7] && sel_neg == VEC_CFG[i][6:3], "R10 selects",
          {sel_pos, sel_neg}, {VEC_CFG[i][10:7], VEC_CFG[i][6:3]});
      wait_done(n);
      chk(n == VEC_FIRST[i], "R3 first latency", n, VEC_FIRST[i]);
      chk(result == VEC_RES[i], "R5 result mask", result, VEC_RES[i]);
      @(negedge clk);
      chk(!conv_done, "R4 one-cycle done", conv_done, 0);
      wait_done(n);
      chk(n == VEC_STEADY[i] - 1, "R2 R4 steady period", n + 1, VEC_STEADY[i]);
      wr(VEC_CFG[i] & ~32'h1);
    end

    // R6 abort
    sample_in = 16'hFFFF;
    wr(32'h0000_00C1);
    wait_done(n);
    chk(n == 380, "R6 setup latency", n, 380);
    repeat (20) @(negedge clk);
    sample_in = 16'h1234;
    wr(32'h0000_00C0);
    dones = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (conv_done) dones++;
    end
    chk(dones == 0, "R6 no done after stop", dones, 0);
    chk(result == 16'hFE00, "R6 result kept", result, 16'hFE00);

    // R7 modifying write restarts doubled
    sample_in = 16'hABCD;
    wr(32'h0000_00C1);
    wait_done(n);
    chk(n == 380, "R3 restart latency", n, 380);
    chk(result == 16'hAA00, "R5 result pattern", result, 16'hAA00);
    repeat (10) @(negedge clk);
    wr(32'h0000_0141);
    chk(sel_pos == 4'h2, "R10 select update", sel_pos, 4'h2);
    wait_done(n);
    chk(n == 128, "R7 doubled after change", n, 128);
    wait_done(n);
    chk(n == 64, "R7 normal after doubled", n, 64);

    // R8 identical write
    repeat (10) @(negedge clk);
    wr(32'h0000_0141);
    wait_done(n);
    chk(n == 53, "R8 same write no effect", n, 53);
    wr(32'h0000_0140);

    // R9 reserved codes
    wr(32'h0000_0030);
    chk(reg_rdata == 32'h8000_0030, "R9 neg reserved", reg_rdata, 32'h8000_0030);
    wr(32'h0000_0600);
    chk(reg_rdata == 32'h8000_0600, "R9 pos reserved", reg_rdata, 32'h8000_0600);
    wr(32'h0000_0040);
    chk(reg_rdata == 32'h0000_0040, "R9 flag cleared", reg_rdata, 32'h0000_0040);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule